// File: doc/BRIEF.md
# Channel-Filtering Record Arbiter and Output Queue

This block sits between a set of data-reduction units and the outbound links of a neural acquisition chip. Each unit raises a valid line while it holds a record and passes the record one byte per handshake. A record is always a channel byte, then a two-byte timestamp, then a fixed number of sample bytes. The block grants one unit at a time in rotating order, holds the grant until the whole record has passed, and looks up the channel byte in a per-channel enable mask. Records on enabled channels are written whole into one byte-wide FIFO. Records on disabled or out-of-range channels are read to their end and discarded.

The FIFO feeds a wired port, a radio port, or both at once. A small route register selects the ports. When both are selected, a byte leaves the queue only when both ports accept it. A byte-wide configuration write port loads the enable mask one slice at a time and also loads the route register. Before it accepts the channel byte of a record it will keep, the block checks that the FIFO has room for the complete record, so the queue never holds a partial record.

Top module: `chanq_top`

## Requirements
- R1: After reset, every channel is enabled, the route selects only the wired port (route value 2'b01), the queue is empty, both output valids are low, and no in_ready bit is high.
- R2: Among units with in_valid high, the grant goes to the first unit found by searching upward and wrapping around from the unit after the one granted last. After reset the search starts at unit 0.
- R3: At most one in_ready bit is high. Once the channel byte of a record has been accepted, the grant stays with that unit until all RECORD_BYTES bytes (1 + 2 + SAMPLE_BYTES) have been transferred.
- R4: A record on an enabled channel appears on the output in the order it arrived: channel byte, timestamp high byte, timestamp low byte, then the sample bytes. Records leave the queue in the order they were accepted.
- R5: A record on a disabled channel is still accepted byte by byte to its end, with in_ready high for every byte even when the queue is full, and none of its bytes enters the queue.
- R6: A channel number at or above N_CHAN counts as disabled.
- R7: The channel byte of a record that will be kept is accepted only when the free space in the queue (FIFO_DEPTH minus the occupancy) is at least RECORD_BYTES. Otherwise in_ready stays low and the source waits.
- R8: A configuration write to address s (s < ceil(N_CHAN/8)) loads cfg_wdata into enable bits 8s+7 to 8s. Enable bit c set to 1 enables channel c.
- R9: A configuration write to address ceil(N_CHAN/8) loads the route from cfg_wdata[1:0]: bit 0 selects the wired port (a), bit 1 selects the radio port (b). The valid of a port that is not selected stays low. A byte is removed only when every selected port is ready. With route 2'b00 the queue holds its contents.
- R10: The queue never exceeds FIFO_DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | N_UNITS | Per-unit byte available |
| in_data | input | 8*N_UNITS | Per-unit byte; unit u uses bits 8u+7:8u |
| in_ready | output | N_UNITS | Per-unit byte taken at this edge when valid is also high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Mask slice index, or the route address |
| cfg_wdata | input | 8 | Configuration write data |
| out_a_valid | output | 1 | Wired port byte valid |
| out_a_ready | input | 1 | Wired port accepts byte |
| out_a_data | output | 8 | Wired port byte |
| out_b_valid | output | 1 | Radio port byte valid |
| out_b_ready | input | 1 | Radio port accepts byte |
| out_b_data | output | 8 | Radio port byte |

## Verification
The bench builds the block with three units, 20 channels, two sample bytes and a 12-byte queue. This makes a record 5 bytes long, so the queue holds two records and refuses a third. The stall threshold is therefore reached within a few transfers. Twenty channels leave the top four bits of the third mask slice unused, so channels 20 and 255 test the out-of-range drop path while channel 19 tests the last valid channel. With three units, a unit that keeps its valid high can be seen losing its turn to another unit under the rotating grant.

// File: rtl/chq_pkg.sv
package chq_pkg;
   localparam int BYTE_W   = 8;
   localparam int TS_BYTES = 2;

   typedef enum logic {SEQ_IDLE, SEQ_BURST} seq_state_t;

   function automatic int clog2_min1(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/chq_rr_pick.sv
module chq_rr_pick
   import chq_pkg::*;
#(
   parameter int N = 4,
   localparam int IW = clog2_min1(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic [IW-1:0] win,
   output logic          any
);
   // search from farthest to nearest so the nearest requester wins
   always_comb begin
      win = '0;
      any = 1'b0;
      for (int k = N; k >= 1; k--) begin
         if (req[(int'(last) + k) % N]) begin
            win = IW'((int'(last) + k) % N);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/chq_cfg_regs.sv
module chq_cfg_regs
   import chq_pkg::*;
#(
   parameter int N_CHAN = 96,
   localparam int SLICES = (N_CHAN + 7) / 8,
   localparam int AW = clog2_min1(SLICES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [N_CHAN-1:0] mask,
   output logic [1:0]        route
);
   logic [SLICES*BYTE_W-1:0] mask_q;
   logic [1:0]               route_q;

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[s*BYTE_W +: BYTE_W] <= '1;
         else if (we && int'(addr) == s)
            mask_q[s*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         route_q <= 2'b01;
      else if (we && int'(addr) == SLICES)
         route_q <= wdata[1:0];
   end

   assign mask  = mask_q[N_CHAN-1:0];
   assign route = route_q;
endmodule

// File: rtl/chq_fifo.sv
module chq_fifo
   import chq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int W = 8,
   localparam int PW = clog2_min1(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_en)
            wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
         if (rd_en)
            rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rp];
   assign empty   = (count == '0);
endmodule

// File: rtl/chanq_top.sv
module chanq_top
   import chq_pkg::*;
#(
   parameter int N_UNITS      = 6,
   parameter int N_CHAN       = 96,
   parameter int SAMPLE_BYTES = 4,
   parameter int FIFO_DEPTH   = 64,
   parameter bit DUAL_OUT     = 1'b1,
   localparam int RECORD_BYTES = 1 + TS_BYTES + SAMPLE_BYTES,
   localparam int SLICES = (N_CHAN + 7) / 8,
   localparam int CFG_AW = clog2_min1(SLICES + 1),
   localparam int UW = clog2_min1(N_UNITS),
   localparam int CW = $clog2(FIFO_DEPTH + 1),
   localparam int BCW = clog2_min1(RECORD_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_UNITS-1:0]         in_valid,
   input  logic [N_UNITS*BYTE_W-1:0]  in_data,
   output logic [N_UNITS-1:0]         in_ready,
   input  logic                       cfg_we,
   input  logic [CFG_AW-1:0]          cfg_addr,
   input  logic [BYTE_W-1:0]          cfg_wdata,
   output logic                       out_a_valid,
   input  logic                       out_a_ready,
   output logic [BYTE_W-1:0]          out_a_data,
   output logic                       out_b_valid,
   input  logic                       out_b_ready,
   output logic [BYTE_W-1:0]          out_b_data
);
   initial begin
      assert (FIFO_DEPTH >= RECORD_BYTES) else $error("queue smaller than one record");
      assert (N_CHAN >= 1 && N_CHAN <= 256) else $error("channel count must fit a byte");
      assert (N_UNITS >= 1) else $error("need at least one unit");
      assert (SAMPLE_BYTES >= 1) else $error("need at least one sample byte");
   end

   // configuration
   logic [N_CHAN-1:0] mask;
   logic [1:0]        route;

   chq_cfg_regs #(.N_CHAN(N_CHAN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .mask(mask), .route(route)
   );

   // arbitration
   seq_state_t       st;
   logic [UW-1:0]    gnt, last, win;
   logic             any;
   logic [BCW-1:0]   bcnt;
   logic             keep_q;
   logic             busy;

   chq_rr_pick #(.N(N_UNITS)) u_pick (
      .req(in_valid), .last(last), .win(win), .any(any)
   );

   assign busy = (st == SEQ_BURST);

   // queue status
   logic [CW-1:0]     fifo_cnt;
   logic              fifo_empty;
   logic              wr_en, rd_en;
   logic [BYTE_W-1:0] fifo_q;

   // channel lookup on the winner's first byte
   logic [UW-1:0]     cur_unit;
   logic [BYTE_W-1:0] cur_byte, win_byte;
   logic [255:0]      mask_ext;
   logic              ch_ok, room, xfer;

   assign mask_ext = 256'(mask);
   assign win_byte = in_data[int'(win)*BYTE_W +: BYTE_W];
   assign ch_ok    = (int'(win_byte) < N_CHAN) && mask_ext[win_byte];
   assign room     = (int'(fifo_cnt) + RECORD_BYTES) <= FIFO_DEPTH;
   assign cur_unit = busy ? gnt : win;
   assign cur_byte = in_data[int'(cur_unit)*BYTE_W +: BYTE_W];

   always_comb begin
      in_ready = '0;
      if (busy)
         in_ready[gnt] = 1'b1;
      else if (any && (!ch_ok || room))
         in_ready[win] = 1'b1;
   end

   assign xfer  = |(in_ready & in_valid);
   assign wr_en = xfer && (busy ? keep_q : ch_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SEQ_IDLE;
         gnt    <= '0;
         last   <= UW'(N_UNITS - 1);
         bcnt   <= '0;
         keep_q <= 1'b0;
      end else if (xfer) begin
         if (!busy) begin
            st     <= SEQ_BURST;
            gnt    <= win;
            last   <= win;
            keep_q <= ch_ok;
            bcnt   <= BCW'(1);
         end else if (bcnt == BCW'(RECORD_BYTES - 1)) begin
            st   <= SEQ_IDLE;
            bcnt <= '0;
         end else begin
            bcnt <= bcnt + 1'b1;
         end
      end
   end

   chq_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(cur_byte),
      .rd_en(rd_en), .rd_data(fifo_q), .count(fifo_cnt), .empty(fifo_empty)
   );

   // output routing
   logic sel_a, sel_b;
   assign sel_a = route[0];

   if (DUAL_OUT) begin : g_dual
      assign sel_b      = route[1];
      assign out_b_data = fifo_q;
   end else begin : g_single
      assign sel_b      = 1'b0;
      assign out_b_data = '0;
   end

   assign out_a_valid = !fifo_empty && sel_a;
   assign out_b_valid = !fifo_empty && sel_b;
   assign out_a_data  = fifo_q;
   assign rd_en = !fifo_empty && (sel_a || sel_b)
                  && (!sel_a || out_a_ready) && (!sel_b || out_b_ready);
endmodule

// File: rtl/chq_chk.sv
module chq_chk #(
   parameter int N_UNITS = 6,
   parameter int FIFO_DEPTH = 64,
   parameter int RECORD_BYTES = 7,
   parameter int CW = 7,
   parameter int UW = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_UNITS-1:0] in_ready,
   input logic               busy,
   input logic [UW-1:0]      gnt,
   input logic [CW-1:0]      fifo_cnt,
   input logic               wr_en,
   input logic               keep_q,
   input logic [1:0]         route,
   input logic               out_a_valid,
   input logic               out_b_valid
);
   // R3
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   // R3
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(gnt));

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_cnt) <= FIFO_DEPTH);

   // R7
   room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en) |-> (int'(fifo_cnt) + RECORD_BYTES <= FIFO_DEPTH));

   // R5
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !keep_q) |-> !wr_en);

   // R9
   route_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !route[0] |-> !out_a_valid);

   // R9
   route_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !route[1] |-> !out_b_valid);
endmodule

bind chanq_top chq_chk #(
   .N_UNITS(N_UNITS), .FIFO_DEPTH(FIFO_DEPTH), .RECORD_BYTES(RECORD_BYTES),
   .CW(CW), .UW(UW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy), .gnt(gnt),
   .fifo_cnt(fifo_cnt), .wr_en(wr_en), .keep_q(keep_q), .route(route),
   .out_a_valid(out_a_valid), .out_b_valid(out_b_valid)
);

// File: tb/chanq_top_tb.sv
module chanq_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NU = 3;
   localparam int NCH = 20;
   localparam int SB = 2;
   localparam int DEPTH = 12;
   localparam int AW = 2;
   localparam logic [AW-1:0] ROUTE_ADDR = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NU-1:0] vld = '0;
   logic [7:0] dat [NU];
   logic [NU*8-1:0] in_data;
   logic [NU-1:0] in_ready;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic out_a_valid, out_b_valid;
   logic rdy_a = 1'b1, rdy_b = 1'b1;
   logic [7:0] out_a_data, out_b_data;

   logic [1:0] route_bench = 2'b01;
   logic [7:0] exp_q [$];
   int n_chk = 0;
   int n_fail = 0;

   assign in_data = {dat[2], dat[1], dat[0]};

   always #(CLK_PERIOD/2) clk = ~clk;

   chanq_top #(.N_UNITS(NU), .N_CHAN(NCH), .SAMPLE_BYTES(SB),
               .FIFO_DEPTH(DEPTH), .DUAL_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(in_data),
      .in_ready(in_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .out_a_valid(out_a_valid), .out_a_ready(rdy_a),
      .out_a_data(out_a_data), .out_b_valid(out_b_valid), .out_b_ready(rdy_b),
      .out_b_data(out_b_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // output monitor: checks the byte stream against the expected queue
   always begin
      @(negedge clk);
      #3;
      if (rst_n) begin
         if (!route_bench[1] && out_b_valid)
            chk(1'b0, "R9 port b valid while unselected", 1, 0);
         if (!route_bench[0] && out_a_valid)
            chk(1'b0, "R9 port a valid while unselected", 1, 0);
         if ((route_bench[0] ? out_a_valid : (route_bench[1] && out_b_valid)) &&
             (!route_bench[0] || rdy_a) && (!route_bench[1] || rdy_b)) begin
            logic [7:0] got;
            got = route_bench[0] ? out_a_data : out_b_data;
            if (route_bench == 2'b11)
               chk(out_a_data == out_b_data, "R9 both ports same byte", out_b_data, out_a_data);
            if (exp_q.size() == 0)
               chk(1'b0, "R4 unexpected output byte", got, 0);
            else
               chk(got == exp_q[0], "R4 output byte order", got, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic send_byte(input int u, input logic [7:0] b);
      @(negedge clk);
      vld[u] = 1'b1;
      dat[u] = b;
      #1;
      while (!in_ready[u]) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic send_rec(input int u, input logic [7:0] ch, input logic [15:0] ts,
                           input logic [7:0] s0, input logic [7:0] s1);
      send_byte(u, ch);
      send_byte(u, ts[15:8]);
      send_byte(u, ts[7:0]);
      send_byte(u, s0);
      send_byte(u, s1);
   endtask

   task automatic idle(input int u);
      @(negedge clk);
      vld[u] = 1'b0;
   endtask

   task automatic push_rec(input logic [7:0] ch, input logic [15:0] ts,
                           input logic [7:0] s0, input logic [7:0] s1);
      exp_q.push_back(ch);
      exp_q.push_back(ts[15:8]);
      exp_q.push_back(ts[7:0]);
      exp_q.push_back(s0);
      exp_q.push_back(s1);
   endtask

   task automatic write_cfg(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // {unit, channel, timestamp, sample0, sample1, kept}
   localparam logic [55:0] VEC [8] = '{
      {8'd0, 8'd5,   16'h0102, 8'hA0, 8'hA1, 8'd1},
      {8'd1, 8'd19,  16'h0304, 8'hB0, 8'hB1, 8'd1},
      {8'd2, 8'd20,  16'h0506, 8'hC0, 8'hC1, 8'd0},
      {8'd1, 8'd0,   16'h0708, 8'hD0, 8'hD1, 8'd1},
      {8'd0, 8'd255, 16'h090A, 8'hE0, 8'hE1, 8'd0},
      {8'd2, 8'd12,  16'h0B0C, 8'hF0, 8'hF1, 8'd1},
      {8'd0, 8'd7,   16'h0D0E, 8'h10, 8'h11, 8'd1},
      {8'd1, 8'd21,  16'h0F10, 8'h20, 8'h21, 8'd0}
   };

   initial begin
      for (int i = 0; i < NU; i++) dat[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk); #1;
      chk(out_a_valid == 1'b0, "R1 port a idle after reset", out_a_valid, 0);
      chk(out_b_valid == 1'b0, "R1 port b idle after reset", out_b_valid, 0);
      chk(in_ready == '0, "R1 no ready after reset", in_ready, 0);

      // R2 rotation: unit 0 streams two records, unit 2 one; 2 cuts in
      push_rec(8'd1, 16'h1111, 8'h01, 8'h02);
      push_rec(8'd2, 16'h2222, 8'h03, 8'h04);
      push_rec(8'd3, 16'h3333, 8'h05, 8'h06);
      fork
         begin
            send_rec(0, 8'd1, 16'h1111, 8'h01, 8'h02);
            send_rec(0, 8'd3, 16'h3333, 8'h05, 8'h06);
            idle(0);
         end
         begin
            send_rec(2, 8'd2, 16'h2222, 8'h03, 8'h04);
            idle(2);
         end
      join
      drain();
      chk(exp_q.size() == 0, "R2 rotating order complete", exp_q.size(), 0);

      // table walk: R4 ordering, R6 out-of-range drops, R1 all channels enabled
      for (int i = 0; i < 8; i++) begin
         logic [55:0] v;
         v = VEC[i];
         if (v[7:0] != 0) push_rec(v[47:40], v[39:24], v[23:16], v[15:8]);
         send_rec(int'(v[55:48]), v[47:40], v[39:24], v[23:16], v[15:8]);
         idle(int'(v[55:48]));
      end
      drain();
      chk(out_a_valid == 1'b0, "R6 dropped records left nothing queued", out_a_valid, 0);

      // R8 mask slices: disable channel 0 and channel 9
      write_cfg(2'd0, 8'hFE);
      write_cfg(2'd1, 8'hFD);
      send_rec(1, 8'd0, 16'h4444, 8'h44, 8'h45);
      idle(1);
      send_rec(2, 8'd9, 16'h5555, 8'h55, 8'h56);
      idle(2);
      repeat (3) @(negedge clk);
      #1;
      chk(out_a_valid == 1'b0, "R5 disabled channels consumed and dropped", out_a_valid, 0);
      push_rec(8'd1, 16'h6666, 8'h66, 8'h67);
      send_rec(0, 8'd1, 16'h6666, 8'h66, 8'h67);
      idle(0);
      push_rec(8'd8, 16'h7777, 8'h77, 8'h78);
      send_rec(1, 8'd8, 16'h7777, 8'h77, 8'h78);
      idle(1);
      push_rec(8'd16, 16'h8888, 8'h88, 8'h89);
      send_rec(2, 8'd16, 16'h8888, 8'h88, 8'h89);
      idle(2);
      drain();
      chk(exp_q.size() == 0, "R8 enabled channels passed", exp_q.size(), 0);
      write_cfg(2'd0, 8'hFF);
      write_cfg(2'd1, 8'hFF);

      // R7 room check: fill two records with the output blocked
      rdy_a = 1'b0;
      push_rec(8'd3, 16'h9999, 8'h91, 8'h92);
      send_rec(1, 8'd3, 16'h9999, 8'h91, 8'h92);
      push_rec(8'd4, 16'hAAAA, 8'hA2, 8'hA3);
      send_rec(1, 8'd4, 16'hAAAA, 8'hA2, 8'hA3);
      idle(1);
      #1;
      chk(out_a_valid == 1'b1, "R7 queue holds data while blocked", out_a_valid, 1);
      // R5 disabled record still flows while the queue is nearly full
      send_rec(2, 8'd20, 16'hBBBB, 8'hB3, 8'hB4);
      idle(2);
      chk(1'b1, "R5 disabled record consumed with queue full", 1, 1);
      push_rec(8'd6, 16'hCCCC, 8'hC4, 8'hC5);
      fork
         begin
            send_rec(0, 8'd6, 16'hCCCC, 8'hC4, 8'hC5);
            idle(0);
         end
         begin
            repeat (4) @(negedge clk);
            #2;
            chk(in_ready[0] == 1'b0, "R7 stall without room", in_ready[0], 0);
            chk(vld[0] == 1'b1, "R7 source still waiting", vld[0], 1);
            rdy_a = 1'b1;
         end
      join
      drain();
      chk(exp_q.size() == 0, "R7 stalled record delivered after drain", exp_q.size(), 0);

      // R9 radio port only
      write_cfg(ROUTE_ADDR, 8'h02);
      route_bench = 2'b10;
      rdy_b = 1'b0;
      push_rec(8'd10, 16'hDDDD, 8'hD5, 8'hD6);
      send_rec(0, 8'd10, 16'hDDDD, 8'hD5, 8'hD6);
      idle(0);
      repeat (2) @(negedge clk);
      #1;
      chk(out_a_valid == 1'b0, "R9 wired port quiet on radio route", out_a_valid, 0);
      chk(out_b_valid == 1'b1, "R9 radio port valid", out_b_valid, 1);
      chk(out_b_data == 8'd10, "R9 radio port first byte", out_b_data, 10);
      rdy_b = 1'b1;
      drain();

      // R9 both ports: byte held until both ready
      write_cfg(ROUTE_ADDR, 8'h03);
      route_bench = 2'b11;
      rdy_b = 1'b0;
      push_rec(8'd11, 16'hEEEE, 8'hE6, 8'hE7);
      send_rec(1, 8'd11, 16'hEEEE, 8'hE6, 8'hE7);
      idle(1);
      repeat (4) @(negedge clk);
      #1;
      chk(out_a_valid == 1'b1 && out_a_data == 8'd11, "R9 held until both ready",
          out_a_data, 11);
      rdy_b = 1'b1;
      drain();
      chk(exp_q.size() == 0, "R9 dual route drained", exp_q.size(), 0);

      write_cfg(ROUTE_ADDR, 8'h01);
      route_bench = 2'b01;
      repeat (2) @(negedge clk);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule